// File: doc/BRIEF.md
# Nested Loop Address Stack

This block keeps the return-to-start addresses of zero-overhead hardware loops for a processor's loop controller. When a loop starts, the loop unit pushes the address of the first instruction in the loop body. The fetch unit reads the top entry to branch back to that address on each iteration. When the loop ends, either at its natural end or through an explicit exit, the entry is popped. The store holds two entries of 16 bits, so two hardware loops can nest. A single-instruction repeat never touches the stack, so one repeat may still nest inside the inner loop.

Two flag bits travel with the stack. The loop-active flag says whether any loop is running. The saved-outer flag records what the loop-active flag was before the innermost loop began. A push copies the loop-active flag into the saved-outer flag and then sets the loop-active flag. A pop restores the loop-active flag from the saved-outer flag and clears the saved-outer flag.

A push onto a full stack is dropped and raises a one-cycle, non-maskable overflow interrupt. A pop from an empty stack is ignored and raises nothing. The command inputs are plain one-cycle strobes and have no valid/ready handshake. Every command completes in the cycle it is sampled, so the block never applies back-pressure, and the issuing unit may present a command on every clock.

Top module: `nested_loop_stack`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `depth_o` is 0, `lf_o` is 0, `nl_o` is 0, `ovf_irq_o` is 0 and `top_addr_o` is 0.
- R2: A push (`push_i`=1, `pop_i`=0) with `depth_o` below 2 raises `depth_o` by one on the next cycle, and `top_addr_o` then shows the pushed `push_addr_i`.
- R3: The same accepted push makes `nl_o` equal to the previous `lf_o` and sets `lf_o` to 1 on the next cycle. As a result, `lf_o` is 1 exactly when the depth is nonzero, and `nl_o` is 1 exactly when the depth is 2.
- R4: A pop (`pop_i`=1) with `depth_o` nonzero lowers `depth_o` by one on the next cycle. `top_addr_o` then shows the entry pushed before the one that was removed (last-in-first-out), `lf_o` takes the previous `nl_o`, and `nl_o` becomes 0.
- R5: A push with `depth_o` equal to 2 writes nothing. On the next cycle `depth_o`, `top_addr_o`, `lf_o` and `nl_o` are unchanged and `ovf_irq_o` is 1.
- R6: A pop with `depth_o` equal to 0 leaves `depth_o`, `lf_o` and `nl_o` at 0 and leaves `ovf_irq_o` at 0.
- R7: When `push_i` and `pop_i` are both 1 in the same cycle, only the pop is performed, and `push_addr_i` is ignored.
- R8: `top_addr_o` reads 0 whenever `depth_o` is 0, and otherwise shows the most recently pushed entry that is still held.
- R9: `ovf_irq_o` is high for exactly one cycle per overflowing push: it is 1 in a cycle only if the previous cycle held a push-only request with `depth_o` equal to 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Loop-begin strobe: push `push_addr_i` |
| push_addr_i | input | 16 | Address of the first instruction in the loop body |
| pop_i | input | 1 | Loop-end or loop-exit strobe: discard the top entry |
| top_addr_o | output | 16 | Top entry; 0 when empty |
| lf_o | output | 1 | Loop-active flag |
| nl_o | output | 1 | Saved-outer-loop flag |
| depth_o | output | 2 | Number of entries held (0 to 2) |
| ovf_irq_o | output | 1 | Non-maskable overflow interrupt pulse |

## Verification
Every piece of state in this block reaches a port directly, so a wrong internal state appears at the ports one clock after the command that caused it:
- A wrong pointer shows as a wrong `depth_o` value.
- A misplaced write shows on `top_addr_o`, either at once or at the next pop that exposes the lower entry.
- A flag that drifts out of step with the depth breaks the tie between the flags and `depth_o` stated in R3.

The reference model is compared against all outputs on every cycle. The hazards it targets are pushes at full depth, pops at zero depth, and simultaneous requests, because those are where a wrong write or a missing interrupt would hide.

// File: rtl/lstk_pkg.sv
package lstk_pkg;
  // Resolved command for one cycle.
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2,
    OP_OVF  = 2'd3
  } lstk_op_e;
endpackage

// File: rtl/lstk_ctrl.sv
module lstk_ctrl
  import lstk_pkg::*;
#(
  parameter int DEPTH = 2,
  localparam int PW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          pop_i,
  output lstk_op_e      op_o,
  output logic [PW-1:0] depth_o,
  output logic          ovf_o
);
  logic [PW-1:0] depth_q;
  logic          full, empty;

  assign full  = (depth_q == PW'(DEPTH));
  assign empty = (depth_q == '0);

  // Pop has priority over push; an empty pop and a full push both resolve without touching storage.
  always_comb begin
    op_o = OP_IDLE;
    if (pop_i) begin
      if (!empty) op_o = OP_POP;
    end else if (push_i) begin
      op_o = full ? OP_OVF : OP_PUSH;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth_q <= '0;
      ovf_o   <= 1'b0;
    end else begin
      ovf_o <= (op_o == OP_OVF);
      unique case (op_o)
        OP_PUSH: depth_q <= depth_q + PW'(1);
        OP_POP:  depth_q <= depth_q - PW'(1);
        default: depth_q <= depth_q;
      endcase
    end
  end

  assign depth_o = depth_q;
endmodule

// File: rtl/lstk_store.sv
module lstk_store
  import lstk_pkg::*;
#(
  parameter int DEPTH = 2,
  parameter int AW    = 16,
  localparam int PW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  lstk_op_e      op_i,
  input  logic [PW-1:0] depth_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] top_o
);
  logic [AW-1:0] ent [DEPTH];

  // One register per slot; the slot written is the one at the current depth.
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ent[g] <= '0;
      else if (op_i == OP_PUSH && depth_i == PW'(g)) ent[g] <= addr_i;
    end
  end

  // The top entry sits at slot depth-1; the output reads zero when empty.
  always_comb begin
    top_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (depth_i == PW'(i + 1)) top_o = ent[i];
    end
  end
endmodule

// File: rtl/lstk_flags.sv
module lstk_flags
  import lstk_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  lstk_op_e op_i,
  output logic     lf_o,
  output logic     nl_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lf_o <= 1'b0;
      nl_o <= 1'b0;
    end else begin
      unique case (op_i)
        OP_PUSH: begin nl_o <= lf_o; lf_o <= 1'b1; end
        OP_POP:  begin lf_o <= nl_o; nl_o <= 1'b0; end
        default: begin lf_o <= lf_o; nl_o <= nl_o; end
      endcase
    end
  end
endmodule

// File: rtl/nested_loop_stack.sv
module nested_loop_stack
  import lstk_pkg::*;
#(
  parameter int DEPTH = 2,
  parameter int AW    = 16,
  localparam int PW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic [AW-1:0] push_addr_i,
  input  logic          pop_i,
  output logic [AW-1:0] top_addr_o,
  output logic          lf_o,
  output logic          nl_o,
  output logic [PW-1:0] depth_o,
  output logic          ovf_irq_o
);
  lstk_op_e      op;
  logic [PW-1:0] depth;

  lstk_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i),
    .op_o(op), .depth_o(depth), .ovf_o(ovf_irq_o)
  );

  lstk_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk(clk), .rst_n(rst_n), .op_i(op), .depth_i(depth),
    .addr_i(push_addr_i), .top_o(top_addr_o)
  );

  lstk_flags u_flags (
    .clk(clk), .rst_n(rst_n), .op_i(op), .lf_o(lf_o), .nl_o(nl_o)
  );

  assign depth_o = depth;
endmodule

// File: rtl/lstk_checker.sv
module lstk_checker #(
  parameter int DEPTH = 2,
  parameter int AW    = 16,
  localparam int PW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          push_i,
  input logic [AW-1:0] push_addr_i,
  input logic          pop_i,
  input logic [AW-1:0] top_addr_o,
  input logic          lf_o,
  input logic          nl_o,
  input logic [PW-1:0] depth_o,
  input logic          ovf_irq_o
);
  // R2: accepted push grows depth and exposes the new address
  a_r2_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && depth_o < PW'(DEPTH)) |=>
      (depth_o == $past(depth_o) + PW'(1) && top_addr_o == $past(push_addr_i)));

  // R3: push moves the loop-active flag into the saved flag
  a_r3_flag_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && depth_o < PW'(DEPTH)) |=> (lf_o && nl_o == $past(lf_o)));

  // R3: flags stay in step with the pointer
  a_r3_flags_track_depth: assert property (@(posedge clk) disable iff (!rst_n)
    (lf_o == (depth_o != '0)) && (nl_o == (depth_o == PW'(DEPTH))));

  // R4: pop shrinks depth and restores the flag
  a_r4_pop_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && depth_o != '0) |=>
      (depth_o == $past(depth_o) - PW'(1) && lf_o == $past(nl_o) && !nl_o));

  // R5: overflowing push changes nothing and interrupts
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && depth_o == PW'(DEPTH)) |=>
      (ovf_irq_o && $stable(depth_o) && $stable(top_addr_o) && $stable(lf_o) && $stable(nl_o)));

  // R6: empty pop stays empty and silent
  a_r6_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && depth_o == '0) |=> (depth_o == '0 && !ovf_irq_o && !lf_o));

  // R9: interrupt only after an overflowing push
  a_r9_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_irq_o |-> $past(push_i && !pop_i && depth_o == PW'(DEPTH)));
endmodule

bind nested_loop_stack lstk_checker #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .push_i(push_i), .push_addr_i(push_addr_i),
  .pop_i(pop_i), .top_addr_o(top_addr_o), .lf_o(lf_o), .nl_o(nl_o),
  .depth_o(depth_o), .ovf_irq_o(ovf_irq_o)
);

// File: tb/nested_loop_stack_bench.sv
`timescale 1ns/1ps
module nested_loop_stack_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_i = 1'b0;
  logic        pop_i = 1'b0;
  logic [15:0] push_addr_i = '0;
  logic [15:0] top_addr_o;
  logic        lf_o, nl_o, ovf_irq_o;
  logic [1:0]  depth_o;

  int checks = 0;
  int failures = 0;

  // Reference model state
  logic [15:0] mq[$];
  bit m_lf = 0, m_nl = 0, m_irq = 0;

  always #2.5 clk = ~clk;

  nested_loop_stack u_nested_loop_stack (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .push_addr_i(push_addr_i),
    .pop_i(pop_i), .top_addr_o(top_addr_o), .lf_o(lf_o), .nl_o(nl_o),
    .depth_o(depth_o), .ovf_irq_o(ovf_irq_o)
  );

  function automatic logic [15:0] m_top();
    return (mq.size() == 0) ? 16'h0 : mq[mq.size()-1];
  endfunction

  task automatic compare(string tag);
    logic [15:0] et;
    et = m_top();
    checks++;
    if (depth_o !== 2'(mq.size()) || top_addr_o !== et || lf_o !== m_lf ||
        nl_o !== m_nl || ovf_irq_o !== m_irq) begin
      failures++;
      $display("FAIL %s: depth=%0d top=%h lf=%b nl=%b irq=%b expected depth=%0d top=%h lf=%b nl=%b irq=%b",
               tag, depth_o, top_addr_o, lf_o, nl_o, ovf_irq_o,
               mq.size(), et, m_lf, m_nl, m_irq);
    end
  endtask

  // One clock: drive, model the edge, sample at the falling edge.
  task automatic cyc(bit pu, bit po, logic [15:0] a, string tag);
    push_i = pu; pop_i = po; push_addr_i = a;
    @(posedge clk);
    m_irq = 0;
    if (po) begin
      if (mq.size() > 0) begin
        void'(mq.pop_back());
        m_lf = m_nl; m_nl = 0;
      end
    end else if (pu) begin
      if (mq.size() < 2) begin
        mq.push_back(a);
        m_nl = m_lf; m_lf = 1;
      end else begin
        m_irq = 1;
      end
    end
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R1 reset held");
    rst_n = 1'b1;
    cyc(0, 0, 16'h0, "R1 after release");
    cyc(0, 1, 16'h0, "R6 pop empty");
    cyc(1, 0, 16'h1200, "R2 first push");
    cyc(1, 0, 16'h3456, "R3 nested push");
    cyc(1, 0, 16'hDEAD, "R5 overflow push");
    cyc(0, 0, 16'h0, "R9 irq one cycle");
    cyc(1, 0, 16'hBEEF, "R5 second overflow");
    cyc(1, 0, 16'hCAFE, "R9 back-to-back overflow");
    cyc(1, 1, 16'h7777, "R7 push+pop at full");
    cyc(0, 0, 16'h0, "R4 lower entry exposed");
    cyc(0, 1, 16'h0, "R4 pop to empty");
    cyc(0, 0, 16'h0, "R8 top zero when empty");
    cyc(1, 1, 16'h5555, "R7 push+pop at empty");
    cyc(1, 0, 16'h0A0A, "R2 refill");
    cyc(1, 1, 16'hFFFF, "R7 push+pop at depth one");
    cyc(1, 0, 16'h0001, "R3 push from empty");
    cyc(1, 0, 16'hFFFE, "R3 push to full");
    cyc(0, 1, 16'h0, "R4 pop from full");
    for (int i = 0; i < 400; i++) begin
      cyc(1'($urandom_range(0, 1)), 1'($urandom_range(0, 2) == 0),
          16'($urandom), "RAND mix");
    end
    rst_n = 1'b0;
    mq.delete(); m_lf = 0; m_nl = 0; m_irq = 0;
    @(negedge clk);
    compare("R1 reset mid-run");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule